// File: doc/BRIEF.md
# Piezo Drive Period Sequencer

This block sits between the register bank and the waveform generator of a piezo actuator driver. It decides how many waveform periods are run and in which direction. The waveform generator sends a one-cycle strobe at the end of every period. The sequencer counts these strobes in groups of one step, where a step is the programmed number of periods. It raises a run request while periods are to be driven and holds a busy flag while any sequence is in progress.

Two activities share the counting hardware. The first is a homing sequence, launched when the enable bit rises while homing is not suppressed. The actuator first travels a long distance in the selected direction. It then rests, and finally returns a short distance the other way. The second is a drive command. Each command write gives a number of steps, and writes that arrive while a drive is running add to the remaining total. Clearing the enable bit aborts everything at once. A change of direction, or a write of zero, discards any pending drive.

Top module: `pdc_drive_seq`

## Requirements
- R1: After reset, busy and run_req are 0 and dir_out equals dir_sel.
- R2: When en goes from 0 to 1 while init_skip is 0, busy and run_req are 1 from the next cycle on. When init_skip is 1, the same edge starts nothing and busy stays 0.
- R3: The first homing phase runs (step_code+1)×16×(home_code+1) periods. During it, dir_out equals the value dir_sel had when homing started. home_code is a 4-bit code, so this phase covers 16 to 256 steps.
- R4: After the first homing phase, busy stays 1 and run_req is 0 for 4×(step_code+1) strobes.
- R5: The last homing phase runs (step_code+1)×K periods with dir_out inverted. K comes from swing_code as follows: 0→2, 1→1, 2→3, 3→4. busy falls to 0 when this phase ends.
- R6: A write with cnt_wr=1 and a non-zero cnt_data while idle runs (step_code+1)×cnt_data periods with dir_out equal to dir_sel. busy then returns to 0.
- R7: A non-zero write during a drive adds cnt_data steps to those still pending. The pending total never exceeds 512 steps.
- R8: One cycle after en is sampled 0, busy and run_req are 0 and all pending steps are discarded. Writes made while en is 0 have no effect.
- R9: A change of dir_sel during a drive stops it and discards the pending steps. If a non-zero write arrives in the same cycle, only that write's count runs, in the new direction.
- R10: A write of cnt_data=0 stops a running drive; busy is 0 on the next cycle.
- R11: Drive writes that arrive during homing have no effect on the homing phase lengths.
- R12: Period strobes that arrive while idle do not advance the step counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable bit; rising edge may launch homing, low aborts |
| init_skip | input | 1 | 1 suppresses homing on the enable edge |
| dir_sel | input | 1 | Selected direction |
| step_code | input | 8 | Periods per step minus one |
| home_code | input | 4 | First homing phase length code, 16×(code+1) steps |
| swing_code | input | 2 | Return phase length code |
| cnt_wr | input | 1 | Drive command write strobe |
| cnt_data | input | 7 | Drive command step count, 0 stops |
| period_done | input | 1 | One-cycle strobe at the end of each waveform period |
| dir_out | output | 1 | Direction for the waveform generator |
| run_req | output | 1 | Periods are to be driven |
| busy | output | 1 | A homing or drive sequence is in progress |

## Verification
The assertions watch several behaviours on every cycle. An aborted or zero-written drive must be idle one cycle later, and a direction flip must end a drive. The enable edge must launch homing, the pending total must stay under its cap, and the direction must hold steady through the return phase. Exact period counts can only be shown by the bench scenarios, which feed strobes one at a time and tally how many land in each direction and in the rest phase. The same applies to the nonlinear code decoding, the accumulation of overlapping writes and the immunity of homing to stray commands.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    localparam int STEP_W       = 8;
    localparam int CNT_W        = 7;
    localparam int HOME_W       = 4;
    localparam int SWING_W      = 2;
    localparam int UNIT_CAP     = 512;
    localparam int UNIT_W       = $clog2(UNIT_CAP + 1);
    localparam int HOME_QUANTUM = 16;
    localparam int REST_UNITS   = 4;

    typedef logic [UNIT_W-1:0] units_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOME_MOVE,
        ST_HOME_WAIT,
        ST_HOME_BACK,
        ST_DRIVE
    } seq_state_t;

    // Control word issued by the sequencer to the unit counter
    typedef struct packed {
        logic   clr;
        logic   load;
        units_t load_val;
        logic   add;
    } unit_cmd_t;

    function automatic units_t home_units(input logic [HOME_W-1:0] code);
        return units_t'(HOME_QUANTUM) * (units_t'(code) + units_t'(1));
    endfunction

    function automatic units_t swing_units(input logic [SWING_W-1:0] code);
        units_t r;
        case (code)
            2'd0:    r = units_t'(2);
            2'd1:    r = units_t'(1);
            2'd2:    r = units_t'(3);
            default: r = units_t'(4);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pdc_step_div.sv
module pdc_step_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         active,
    input  logic         strobe,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] cnt;

    assign tick = active && strobe && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (active && strobe) begin
            cnt <= tick ? '0 : cnt + W'(1);
        end
    end
endmodule

// File: rtl/pdc_unit_ctr.sv
module pdc_unit_ctr #(
    parameter int W   = 10,
    parameter int CAP = 512
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    input  logic         add,
    input  logic [W-1:0] add_val,
    output logic [W-1:0] count,
    output logic         last
);
    logic [W:0] sum;
    logic [W:0] sat;

    always_comb begin
        sum = {1'b0, count} - {{W{1'b0}}, dec} + (add ? {1'b0, add_val} : '0);
        sat = (sum > (W+1)'(CAP)) ? (W+1)'(CAP) : sum;
    end

    assign last = (count == W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec || add) begin
            count <= sat[W-1:0];
        end
    end
endmodule

// File: rtl/pdc_drive_seq.sv
module pdc_drive_seq
    import pdc_pkg::*;
#(
    parameter int STEP_BITS = STEP_W,
    parameter int CNT_BITS  = CNT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 init_skip,
    input  logic                 dir_sel,
    input  logic [STEP_BITS-1:0] step_code,
    input  logic [HOME_W-1:0]    home_code,
    input  logic [SWING_W-1:0]   swing_code,
    input  logic                 cnt_wr,
    input  logic [CNT_BITS-1:0]  cnt_data,
    input  logic                 period_done,
    output logic                 dir_out,
    output logic                 run_req,
    output logic                 busy
);
    seq_state_t state, state_nxt;
    unit_cmd_t  cmd;
    logic       en_q, dir_q, home_dir;
    logic       step_clr, tick, last;
    logic       home_start, dir_chg, active;
    units_t     unit_count;

    assign home_start = en && !en_q && !init_skip;
    assign dir_chg    = dir_sel ^ dir_q;
    assign active     = (state != ST_IDLE);

    pdc_step_div #(.W(STEP_BITS)) u_step (
        .clk(clk), .rst(rst), .clr(step_clr), .active(active),
        .strobe(period_done), .limit(step_code), .tick(tick)
    );

    pdc_unit_ctr #(.W(UNIT_W), .CAP(UNIT_CAP)) u_units (
        .clk(clk), .rst(rst), .clr(cmd.clr), .load(cmd.load),
        .load_val(cmd.load_val), .dec(tick), .add(cmd.add),
        .add_val(units_t'(cnt_data)), .count(unit_count), .last(last)
    );

    always_comb begin
        state_nxt = state;
        cmd       = '0;
        step_clr  = 1'b0;
        if (!en) begin
            state_nxt = ST_IDLE;
            cmd.clr   = 1'b1;
            step_clr  = 1'b1;
        end else if (home_start) begin
            state_nxt    = ST_HOME_MOVE;
            cmd.load     = 1'b1;
            cmd.load_val = home_units(home_code);
            step_clr     = 1'b1;
        end else begin
            case (state)
                ST_HOME_MOVE: if (tick && last) begin
                    state_nxt    = ST_HOME_WAIT;
                    cmd.load     = 1'b1;
                    cmd.load_val = units_t'(REST_UNITS);
                end
                ST_HOME_WAIT: if (tick && last) begin
                    state_nxt    = ST_HOME_BACK;
                    cmd.load     = 1'b1;
                    cmd.load_val = swing_units(swing_code);
                end
                ST_HOME_BACK: if (tick && last) begin
                    state_nxt = ST_IDLE;
                end
                default: begin
                    if (cnt_wr) begin
                        if (cnt_data == '0) begin
                            state_nxt = ST_IDLE;
                            cmd.clr   = 1'b1;
                            step_clr  = 1'b1;
                        end else if (dir_chg || state == ST_IDLE) begin
                            state_nxt    = ST_DRIVE;
                            cmd.load     = 1'b1;
                            cmd.load_val = units_t'(cnt_data);
                            step_clr     = 1'b1;
                        end else begin
                            cmd.add = 1'b1;
                        end
                    end else if (dir_chg) begin
                        state_nxt = ST_IDLE;
                        cmd.clr   = 1'b1;
                        step_clr  = 1'b1;
                    end else if (state == ST_DRIVE && tick && last) begin
                        state_nxt = ST_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            en_q     <= 1'b0;
            dir_q    <= 1'b0;
            home_dir <= 1'b0;
        end else begin
            state <= state_nxt;
            en_q  <= en;
            dir_q <= dir_sel;
            if (home_start) home_dir <= dir_sel;
        end
    end

    always_comb begin
        case (state)
            ST_HOME_MOVE, ST_HOME_WAIT: dir_out = home_dir;
            ST_HOME_BACK:               dir_out = ~home_dir;
            default:                    dir_out = dir_sel;
        endcase
    end

    assign run_req = (state == ST_HOME_MOVE) || (state == ST_HOME_BACK) || (state == ST_DRIVE);
    assign busy    = active;
endmodule

// File: rtl/pdc_drive_seq_chk.sv
module pdc_drive_seq_chk
    import pdc_pkg::*;
#(
    parameter int CNT_BITS = CNT_W
) (
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic                init_skip,
    input logic                dir_sel,
    input logic                cnt_wr,
    input logic [CNT_BITS-1:0] cnt_data,
    input logic                dir_out,
    input logic                run_req,
    input logic                busy,
    input seq_state_t          state,
    input units_t              units
);
    AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!busy && !run_req)); // R8

    AST_HOME_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (en && !$past(en) && !init_skip) |=> (busy && run_req)); // R2

    AST_ZERO_WRITE_STOP: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_DRIVE && cnt_wr && cnt_data == '0) |=> !busy); // R10

    AST_DIR_FLIP_STOP: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_DRIVE && !cnt_wr && dir_sel != $past(dir_sel)) |=> !busy); // R9

    AST_UNIT_CAP: assert property (@(posedge clk) disable iff (rst)
        units <= units_t'(UNIT_CAP)); // R7

    AST_BACK_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOME_BACK && $past(state) == ST_HOME_BACK) |-> $stable(dir_out)); // R5
endmodule

bind pdc_drive_seq pdc_drive_seq_chk #(.CNT_BITS(CNT_BITS)) i_chk (
    .clk(clk), .rst(rst), .en(en), .init_skip(init_skip), .dir_sel(dir_sel),
    .cnt_wr(cnt_wr), .cnt_data(cnt_data), .dir_out(dir_out), .run_req(run_req),
    .busy(busy), .state(state), .units(unit_count)
);

// File: tb/test_pdc_drive_seq.sv
module test_pdc_drive_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       init_skip = 1'b0;
    logic       dir_sel = 1'b0;
    logic [7:0] step_code = '0;
    logic [3:0] home_code = '0;
    logic [1:0] swing_code = '0;
    logic       cnt_wr = 1'b0;
    logic [6:0] cnt_data = '0;
    logic       period_done = 1'b0;
    logic       dir_out, run_req, busy;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    pdc_drive_seq i_pdc_drive_seq (
        .clk(clk), .rst(rst), .en(en), .init_skip(init_skip), .dir_sel(dir_sel),
        .step_code(step_code), .home_code(home_code), .swing_code(swing_code),
        .cnt_wr(cnt_wr), .cnt_data(cnt_data), .period_done(period_done),
        .dir_out(dir_out), .run_req(run_req), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int swing_len(input int code);
        case (code)
            0: return 2;
            1: return 1;
            2: return 3;
            default: return 4;
        endcase
    endfunction

    task automatic pulse_n(input int n);
        for (int i = 0; i < n; i++) begin
            period_done = 1'b1;
            @(negedge clk);
            period_done = 1'b0;
        end
    endtask

    task automatic write_cnt(input int d);
        cnt_wr = 1'b1;
        cnt_data = 7'(d);
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    // Feeds strobes until idle, tallying each by the phase it lands in
    task automatic run_count(input logic dir_a, output int n_a, output int n_b, output int n_w);
        n_a = 0; n_b = 0; n_w = 0;
        for (int i = 0; i < 5000; i++) begin
            if (!busy) break;
            if (!run_req) n_w++;
            else if (dir_out == dir_a) n_a++;
            else n_b++;
            period_done = 1'b1;
            @(negedge clk);
            period_done = 1'b0;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(run_req == 1'b0, "R1 run_req", run_req, 0);
        check(dir_out == dir_sel, "R1 dir_out", dir_out, dir_sel);
    endtask

    task automatic t_homing(input int s, input int ic, input int rc, input logic d, input bit inject);
        int a, b, w;
        en = 1'b0; init_skip = 1'b0; dir_sel = d;
        step_code = 8'(s); home_code = 4'(ic); swing_code = 2'(rc);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        check(busy && run_req, "R2 homing launched", busy, 1);
        if (inject) begin
            write_cnt(5);  // R11: ignored during homing
            write_cnt(0);
        end
        run_count(d, a, b, w);
        check(a == (s+1)*16*(ic+1), "R3 move periods", a, (s+1)*16*(ic+1));
        check(w == 4*(s+1), "R4 rest periods", w, 4*(s+1));
        check(b == (s+1)*swing_len(rc), inject ? "R11 return periods" : "R5 return periods",
              b, (s+1)*swing_len(rc));
        check(busy == 1'b0, "R5 busy after homing", busy, 0);
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_init_skip();
        en = 1'b0; init_skip = 1'b1;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R2 init_skip suppresses homing", busy, 0);
    endtask

    task automatic t_drive(input int s, input int c, input logic d);
        int a, b, w;
        step_code = 8'(s); dir_sel = d;
        @(negedge clk);
        write_cnt(c);
        check(busy && run_req, "R6 drive started", busy, 1);
        run_count(d, a, b, w);
        check(a == (s+1)*c && b == 0 && w == 0, "R6 drive periods", a, (s+1)*c);
    endtask

    task automatic t_accumulate();
        int a, b, w;
        step_code = 8'd0;
        write_cnt(3);
        write_cnt(4);
        run_count(dir_sel, a, b, w);
        check(a == 7, "R7 added writes", a, 7);
        for (int i = 0; i < 5; i++) write_cnt(127);
        run_count(dir_sel, a, b, w);
        check(a == 512, "R7 capped total", a, 512);
    endtask

    task automatic t_disable();
        step_code = 8'd0;
        write_cnt(20);
        pulse_n(3);
        en = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && run_req == 1'b0, "R8 immediate stop", busy, 0);
        write_cnt(5);
        @(negedge clk);
        check(busy == 1'b0, "R8 write while disabled", busy, 0);
        en = 1'b1;
        @(negedge clk);
        pulse_n(2);
        check(busy == 1'b0, "R8 pending discarded", busy, 0);
    endtask

    task automatic t_dir_flip();
        int a, b, w;
        step_code = 8'd0;
        write_cnt(10);
        pulse_n(3);
        dir_sel = ~dir_sel;
        @(negedge clk);
        check(busy == 1'b0, "R9 flip stops drive", busy, 0);
        write_cnt(10);
        pulse_n(3);
        dir_sel = ~dir_sel;
        write_cnt(2);
        run_count(dir_sel, a, b, w);
        check(a == 2 && b == 0, "R9 flip with write", a, 2);
    endtask

    task automatic t_zero();
        step_code = 8'd1;
        write_cnt(10);
        pulse_n(3);
        write_cnt(0);
        check(busy == 1'b0, "R10 zero write stops", busy, 0);
    endtask

    task automatic t_idle_strobes();
        int a, b, w;
        step_code = 8'd3;
        pulse_n(2);
        write_cnt(1);
        run_count(dir_sel, a, b, w);
        check(a == 4, "R12 idle strobes ignored", a, 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_homing(1, 1, 0, 1'b0, 1'b0);
        t_homing(0, 0, 2, 1'b1, 1'b1);
        t_homing(0, 15, 3, 1'b0, 1'b0);
        t_homing(2, 0, 1, 1'b1, 1'b0);
        t_init_skip();
        t_drive(2, 5, 1'b0);
        t_drive(0, 1, 1'b1);
        t_accumulate();
        t_disable();
        t_dir_flip();
        t_zero();
        t_idle_strobes();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule